// File: doc/BRIEF.md
# Frame Buffer Fetch Sequencer

This block starts each display frame from one of two frame buffers in memory. When a frame is requested it reads the 16-bit header word at the start of the current buffer. Bits 14:12 of that word give the pixel depth. From the depth and the loading mode the block works out how many palette bytes come before the pixel data. It then checks that the whole frame fits inside the buffer that was programmed. If it fits, the block sends one line start address at a time to the memory side over a ready/valid handshake.

The controller is armed on the rising edge of its enable input. At that edge it checks the address-valid flags of the buffers. Once armed, each frame request runs one header read, one size check and one line sequence. After that the block reports a done pulse. If a frame does not fit, the block sets a sticky sync error and disarms itself. In dual-buffer mode it alternates between the two buffers on every frame it starts. A sub-panel setting can move the first line of the sequence or cut the sequence short. Converting pixel colours and arbitrating memory access are left to other blocks.

Top module: `fb_fetch_seq`

## Requirements
- R1: Header bits 14:12 give the depth code: 1 is 2 bpp, 2 is 4 bpp, 3 is 8 bpp, and 4 to 7 are 16 bpp. `bpp_o` shows the depth. `line_bytes_o` equals (width × bpp) / 8, where width = `width_m1_i` + 1.
- R2: A depth code of 0 fetches no frame. No line address appears, no condition bit is set and no done pulse is given. The controller stays armed.
- R3: `pix_base_o` is the current buffer top plus a palette skip. When the loading mode is not 2, the skip is 0x200 bytes for depth codes 3 and above and 0x20 bytes for codes 1 and 2. When the loading mode is 2 (pixel data only), the skip is 0.
- R4: In loading mode 1 (palette only), a frame request reads the header and then ends. No line addresses and no done pulse are produced.
- R5: `pal_done_o` is set by the first header read after enable in any loading mode other than 2. It stays 0 in mode 2 and is cleared while enable is low.
- R6: A frame overflows when skip + (width × height × bpp) / 8 is greater than (bottom − top) + 2 of the current buffer. The sum is computed at 32 bits or more. On overflow, `sync_err_o` is set, `active_o` is cleared, the frame is skipped and later requests are ignored until the next enable. A frame that needs exactly (bottom − top) + 2 bytes is fetched.
- R7: When a frame passes its checks, `cond_o` pulses bit 0 for buffer 0 or bit 1 for buffer 1. With `dual_i` = 1 the buffer then alternates, and with `dual_i` = 0 it stays at buffer 0. Each enable rise resets it to buffer 0.
- R8: Line n's address is `pix_base_o` + n × `line_bytes_o`. One address is given per accepted handshake, and the address holds while `line_ready_i` is low.
- R9: When `sub_en_i` = 1 and `sub_from_start_i` = 1, the lines run from `sub_line_i` to height − 1. When `sub_en_i` = 1 and `sub_from_start_i` = 0, the lines run from 0 to `sub_line_i` − 1.
- R10: On an enable rise, `addr_ok_i` bits 0 and 1 (top and bottom of buffer 0) are checked. Bits 2 and 3 (top and bottom of buffer 1) are also checked when `dual_i` = 1. If any checked bit is 0, `cond_o` pulses bit 2, `dma_err_irq_o` pulses when `dma_err_ie_i` = 1, and the controller stays unarmed.
- R11: `frame_done_o` pulses for one cycle, in the cycle after the last line address is accepted.
- R12: While `enable_i` is low, `active_o`, `sync_err_o` and `pal_done_o` are cleared and frame requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Controller enable; arms on its rising edge |
| load_mode_i | input | 2 | 0/3 palette+data, 1 palette only, 2 data only |
| dual_i | input | 1 | Alternate between the two buffers |
| dma_err_ie_i | input | 1 | Enables the address error interrupt |
| buf0_top_i | input | AW | Buffer 0 first byte address |
| buf0_bot_i | input | AW | Buffer 0 last address |
| buf1_top_i | input | AW | Buffer 1 first byte address |
| buf1_bot_i | input | AW | Buffer 1 last address |
| addr_ok_i | input | 4 | Valid flags: top0, bot0, top1, bot1 |
| width_m1_i | input | DIMW | Pixels per line minus one |
| height_m1_i | input | DIMW | Lines per frame minus one |
| sub_en_i | input | 1 | Sub-panel enable |
| sub_from_start_i | input | 1 | 1: field is first line; 0: field is line count |
| sub_line_i | input | DIMW | Sub-panel line field |
| frame_go_i | input | 1 | Frame request pulse |
| hdr_req_o | output | 1 | Header read request |
| hdr_addr_o | output | AW | Header address (current buffer top) |
| hdr_valid_i | input | 1 | Header word is present |
| hdr_data_i | input | 16 | Header word |
| line_valid_o | output | 1 | Line address valid |
| line_ready_i | input | 1 | Memory side accepts the line address |
| line_addr_o | output | AW | Line start address |
| pix_base_o | output | AW | Pixel data start of the current frame |
| bpp_o | output | 5 | Bits per pixel |
| line_bytes_o | output | DIMW+2 | Bytes per line |
| frame_done_o | output | 1 | One-cycle frame done pulse |
| sync_err_o | output | 1 | Sticky frame overflow error |
| active_o | output | 1 | Controller armed |
| pal_done_o | output | 1 | Palette header read done |
| cond_o | output | 3 | Pulses: buffer 0, buffer 1, address error |
| dma_err_irq_o | output | 1 | Address error interrupt pulse |

## Verification
Every result comes from a register, so each output is due at a fixed cycle count. A frame request shows up as `hdr_req_o` one cycle later. The header is accepted in the cycle where `hdr_valid_i` is high. Two cycles after the request, the condition pulse, `pix_base_o`, depth, stride, the first line address and any sync error all appear together. The done pulse follows one cycle after the last line handshake. An address fault seen at an enable rise is visible one cycle after the enable rises. The bench drives inputs and samples outputs on the falling edge. Each task steps through exactly these cycle counts and compares at those points. For cases where nothing should happen (depth code 0, palette-only mode, disabled or halted), it watches the outputs over a window of several cycles.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_CHECK,
      ST_LINES,
      ST_HALT
   } fbf_state_e;

   localparam logic [1:0] LOAD_PAL_ONLY  = 2'd1;
   localparam logic [1:0] LOAD_DATA_ONLY = 2'd2;
   localparam int         PAL_FULL_BYTES  = 512;
   localparam int         PAL_SHORT_BYTES = 32;
   localparam int         HDR_DEPTH_LSB   = 12;
endpackage

// File: rtl/fbf_depth_decode.sv
module fbf_depth_decode
   import fbf_pkg::*;
(
   input  logic [2:0] code_i,
   input  logic       data_only_i,
   output logic [4:0] bpp_o,
   output logic [2:0] bpp_log2_o,
   output logic [9:0] skip_o
);
   always_comb begin
      unique case (code_i)
         3'd0:    begin bpp_o = 5'd0;  bpp_log2_o = 3'd0; end
         3'd1:    begin bpp_o = 5'd2;  bpp_log2_o = 3'd1; end
         3'd2:    begin bpp_o = 5'd4;  bpp_log2_o = 3'd2; end
         3'd3:    begin bpp_o = 5'd8;  bpp_log2_o = 3'd3; end
         default: begin bpp_o = 5'd16; bpp_log2_o = 3'd4; end
      endcase
      if (data_only_i)
         skip_o = 10'd0;
      else if (code_i >= 3'd3)
         skip_o = 10'(PAL_FULL_BYTES);
      else
         skip_o = 10'(PAL_SHORT_BYTES);
   end
endmodule

// File: rtl/fbf_size_check.sv
module fbf_size_check #(
   parameter int AW   = 32,
   parameter int DIMW = 10
) (
   input  logic [AW-1:0] top_i,
   input  logic [AW-1:0] bot_i,
   input  logic [DIMW:0] width_i,
   input  logic [DIMW:0] height_i,
   input  logic [2:0]    bpp_log2_i,
   input  logic [9:0]    skip_i,
   output logic          overflow_o
);
   localparam int CW = ((AW > 32) ? AW : 32) + 2;

   logic [CW-1:0] area, need, avail;

   always_comb begin
      area       = CW'(width_i) * CW'(height_i);
      need       = CW'(skip_i) + ((area << bpp_log2_i) >> 3);
      avail      = CW'(bot_i - top_i) + CW'(2);
      overflow_o = need > avail;
   end
endmodule

// File: rtl/fbf_line_gen.sv
module fbf_line_gen #(
   parameter int AW   = 32,
   parameter int DIMW = 10,
   parameter int LBW  = DIMW + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush_i,
   input  logic          load_i,
   input  logic [AW-1:0] start_addr_i,
   input  logic [LBW-1:0] stride_i,
   input  logic [DIMW:0] first_i,
   input  logic [DIMW:0] end_i,
   input  logic          ready_i,
   output logic          valid_o,
   output logic [AW-1:0] addr_o,
   output logic          last_o
);
   logic          busy;
   logic [DIMW:0] cur, end_q;
   logic [AW-1:0] addr;
   logic [LBW-1:0] stride_q;

   assign valid_o = busy;
   assign addr_o  = addr;
   assign last_o  = busy && ready_i && ((cur + 1'b1) == end_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cur      <= '0;
         end_q    <= '0;
         addr     <= '0;
         stride_q <= '0;
      end else if (flush_i) begin
         busy <= 1'b0;
      end else if (load_i) begin
         busy     <= 1'b1;
         cur      <= first_i;
         end_q    <= end_i;
         addr     <= start_addr_i;
         stride_q <= stride_i;
      end else if (busy && ready_i) begin
         cur  <= cur + 1'b1;
         addr <= addr + AW'(stride_q);
         if (last_o) busy <= 1'b0;
      end
   end
endmodule

// File: rtl/fb_fetch_seq.sv
module fb_fetch_seq
   import fbf_pkg::*;
#(
   parameter int AW          = 32,
   parameter int DIMW        = 10,
   parameter int SUBPANEL_EN = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable_i,
   input  logic [1:0]      load_mode_i,
   input  logic            dual_i,
   input  logic            dma_err_ie_i,
   input  logic [AW-1:0]   buf0_top_i,
   input  logic [AW-1:0]   buf0_bot_i,
   input  logic [AW-1:0]   buf1_top_i,
   input  logic [AW-1:0]   buf1_bot_i,
   input  logic [3:0]      addr_ok_i,
   input  logic [DIMW-1:0] width_m1_i,
   input  logic [DIMW-1:0] height_m1_i,
   input  logic            sub_en_i,
   input  logic            sub_from_start_i,
   input  logic [DIMW-1:0] sub_line_i,
   input  logic            frame_go_i,
   output logic            hdr_req_o,
   output logic [AW-1:0]   hdr_addr_o,
   input  logic            hdr_valid_i,
   input  logic [15:0]     hdr_data_i,
   output logic            line_valid_o,
   input  logic            line_ready_i,
   output logic [AW-1:0]   line_addr_o,
   output logic [AW-1:0]   pix_base_o,
   output logic [4:0]      bpp_o,
   output logic [DIMW+1:0] line_bytes_o,
   output logic            frame_done_o,
   output logic            sync_err_o,
   output logic            active_o,
   output logic            pal_done_o,
   output logic [2:0]      cond_o,
   output logic            dma_err_irq_o
);
   localparam int LW  = DIMW + 1;
   localparam int LBW = DIMW + 2;
   localparam int MW  = LW + LBW;

   if (AW < MW) begin : g_bad_aw
      $error("fb_fetch_seq: AW too small for DIMW");
   end
   if (DIMW < 2) begin : g_bad_dimw
      $error("fb_fetch_seq: DIMW must be at least 2");
   end

   fbf_state_e     state;
   logic           en_q, active, buf_idx, pal_done, sync_err, irq, done;
   logic [2:0]     code_q, cond;
   logic [AW-1:0]  pix_base;
   logic [4:0]     bpp_q;
   logic [LBW-1:0] lbytes_q;

   logic [AW-1:0]  cur_top, cur_bot, data_base, start_addr;
   logic [LW-1:0]  width_w, height_w, first_line, end_line;
   logic [4:0]     bpp;
   logic [2:0]     bpp_log2, hdr_code;
   logic [9:0]     skip;
   logic [LW+3:0]  wbits;
   logic [LBW-1:0] stride;
   logic [MW-1:0]  first_off;
   logic           overflow, empty, addrs_ok, gen_last, gen_load;
   logic           unused_hdr_bits;

   assign hdr_code        = hdr_data_i[HDR_DEPTH_LSB +: 3];
   assign unused_hdr_bits = ^{hdr_data_i[15], hdr_data_i[11:0]};
   assign cur_top   = buf_idx ? buf1_top_i : buf0_top_i;
   assign cur_bot   = buf_idx ? buf1_bot_i : buf0_bot_i;
   assign width_w   = LW'(width_m1_i) + 1'b1;
   assign height_w  = LW'(height_m1_i) + 1'b1;
   assign addrs_ok  = addr_ok_i[0] & addr_ok_i[1] &
                      (~dual_i | (addr_ok_i[2] & addr_ok_i[3]));

   fbf_depth_decode u_dec (
      .code_i      (code_q),
      .data_only_i (load_mode_i == LOAD_DATA_ONLY),
      .bpp_o       (bpp),
      .bpp_log2_o  (bpp_log2),
      .skip_o      (skip)
   );

   fbf_size_check #(.AW(AW), .DIMW(DIMW)) u_size (
      .top_i      (cur_top),
      .bot_i      (cur_bot),
      .width_i    (width_w),
      .height_i   (height_w),
      .bpp_log2_i (bpp_log2),
      .skip_i     (skip),
      .overflow_o (overflow)
   );

   if (SUBPANEL_EN != 0) begin : g_sub
      assign first_line = (sub_en_i && sub_from_start_i) ? LW'(sub_line_i) : '0;
      assign end_line   = (sub_en_i && !sub_from_start_i) ? LW'(sub_line_i) : height_w;
   end else begin : g_nosub
      assign first_line = '0;
      assign end_line   = height_w;
   end

   assign wbits      = (LW + 4)'(width_w) << bpp_log2;
   assign stride     = wbits[LW+3:3];
   assign first_off  = MW'(first_line) * MW'(stride);
   assign data_base  = cur_top + AW'(skip);
   assign start_addr = data_base + AW'(first_off);
   assign empty      = first_line >= end_line;
   assign gen_load   = (state == ST_CHECK) && enable_i && !overflow && !empty;

   fbf_line_gen #(.AW(AW), .DIMW(DIMW), .LBW(LBW)) u_lines (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush_i      (!enable_i),
      .load_i       (gen_load),
      .start_addr_i (start_addr),
      .stride_i     (stride),
      .first_i      (first_line),
      .end_i        (end_line),
      .ready_i      (line_ready_i),
      .valid_o      (line_valid_o),
      .addr_o       (line_addr_o),
      .last_o       (gen_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         en_q     <= 1'b0;
         active   <= 1'b0;
         buf_idx  <= 1'b0;
         pal_done <= 1'b0;
         sync_err <= 1'b0;
         irq      <= 1'b0;
         done     <= 1'b0;
         code_q   <= '0;
         cond     <= '0;
         pix_base <= '0;
         bpp_q    <= '0;
         lbytes_q <= '0;
      end else begin
         en_q <= enable_i;
         cond <= '0;
         irq  <= 1'b0;
         done <= 1'b0;
         if (!enable_i) begin
            active   <= 1'b0;
            sync_err <= 1'b0;
            pal_done <= 1'b0;
            state    <= ST_IDLE;
         end else if (!en_q) begin
            buf_idx <= 1'b0;
            if (addrs_ok) begin
               active <= 1'b1;
               state  <= ST_IDLE;
            end else begin
               active <= 1'b0;
               cond   <= 3'b100;
               irq    <= dma_err_ie_i;
               state  <= ST_HALT;
            end
         end else begin
            case (state)
               ST_IDLE: if (active && frame_go_i) state <= ST_HDR;
               ST_HDR: if (hdr_valid_i) begin
                  code_q <= hdr_code;
                  if (load_mode_i != LOAD_DATA_ONLY) pal_done <= 1'b1;
                  if (load_mode_i == LOAD_PAL_ONLY || hdr_code == 3'd0)
                     state <= ST_IDLE;
                  else
                     state <= ST_CHECK;
               end
               ST_CHECK: if (overflow) begin
                  sync_err <= 1'b1;
                  active   <= 1'b0;
                  state    <= ST_HALT;
               end else begin
                  cond     <= buf_idx ? 3'b010 : 3'b001;
                  pix_base <= data_base;
                  bpp_q    <= bpp;
                  lbytes_q <= stride;
                  if (dual_i) buf_idx <= ~buf_idx;
                  if (empty) begin
                     done  <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     state <= ST_LINES;
                  end
               end
               ST_LINES: if (gen_last) begin
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end
               ST_HALT: state <= ST_HALT;
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign hdr_req_o     = (state == ST_HDR) && enable_i;
   assign hdr_addr_o    = cur_top;
   assign pix_base_o    = pix_base;
   assign bpp_o         = bpp_q;
   assign line_bytes_o  = lbytes_q;
   assign frame_done_o  = done;
   assign sync_err_o    = sync_err;
   assign active_o      = active;
   assign pal_done_o    = pal_done;
   assign cond_o        = cond;
   assign dma_err_irq_o = irq;
endmodule

// File: rtl/fbf_seq_checker.sv
module fbf_seq_checker #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          enable_i,
   input logic          active_o,
   input logic          sync_err_o,
   input logic          line_valid_o,
   input logic          line_ready_i,
   input logic [AW-1:0] line_addr_o,
   input logic          hdr_req_o,
   input logic          frame_done_o,
   input logic [2:0]    cond_o,
   input logic          dma_err_irq_o
);
   assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (line_valid_o && !line_ready_i && enable_i) |=> (line_valid_o && $stable(line_addr_o)));

   assert_no_hdr_during_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(hdr_req_o && line_valid_o));

   assert_sync_disables_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_err_o) |-> !active_o);

   assert_cond_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cond_o));

   assert_done_ends_lines_R11: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_o |-> !line_valid_o);

   assert_irq_with_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dma_err_irq_o |-> cond_o[2]);

   assert_disable_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> (!active_o && !sync_err_o && !line_valid_o));
endmodule

bind fb_fetch_seq fbf_seq_checker #(.AW(AW)) u_fbf_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .enable_i      (enable_i),
   .active_o      (active_o),
   .sync_err_o    (sync_err_o),
   .line_valid_o  (line_valid_o),
   .line_ready_i  (line_ready_i),
   .line_addr_o   (line_addr_o),
   .hdr_req_o     (hdr_req_o),
   .frame_done_o  (frame_done_o),
   .cond_o        (cond_o),
   .dma_err_irq_o (dma_err_irq_o)
);

// File: tb/fb_fetch_seq_bench.sv
module fb_fetch_seq_bench;
   localparam int AW = 32;
   localparam int DIMW = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0, dual = 1'b0, ie = 1'b0, frame_go = 1'b0;
   logic [1:0] mode = 2'd0;
   logic [AW-1:0] b0t = 32'h1000, b0b = 32'h9000, b1t = 32'h20000, b1b = 32'h28000;
   logic [3:0] ok = 4'hF;
   logic [DIMW-1:0] wm1 = 10'd15, hm1 = 10'd3, sub_line = '0;
   logic sub_en = 1'b0, sub_start = 1'b0;
   logic hdr_valid = 1'b0, line_ready = 1'b0;
   logic [15:0] hdr_data = '0;
   logic hdr_req, line_valid, frame_done, sync_err, active, pal_done, irq;
   logic [AW-1:0] hdr_addr, line_addr, pix_base;
   logic [4:0] bpp;
   logic [DIMW+1:0] line_bytes;
   logic [2:0] cond;

   int n_checks = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   fb_fetch_seq #(.AW(AW), .DIMW(DIMW)) u_fb_fetch_seq (
      .clk(clk), .rst_n(rst_n), .enable_i(enable), .load_mode_i(mode), .dual_i(dual),
      .dma_err_ie_i(ie), .buf0_top_i(b0t), .buf0_bot_i(b0b), .buf1_top_i(b1t),
      .buf1_bot_i(b1b), .addr_ok_i(ok), .width_m1_i(wm1), .height_m1_i(hm1),
      .sub_en_i(sub_en), .sub_from_start_i(sub_start), .sub_line_i(sub_line),
      .frame_go_i(frame_go), .hdr_req_o(hdr_req), .hdr_addr_o(hdr_addr),
      .hdr_valid_i(hdr_valid), .hdr_data_i(hdr_data), .line_valid_o(line_valid),
      .line_ready_i(line_ready), .line_addr_o(line_addr), .pix_base_o(pix_base),
      .bpp_o(bpp), .line_bytes_o(line_bytes), .frame_done_o(frame_done),
      .sync_err_o(sync_err), .active_o(active), .pal_done_o(pal_done),
      .cond_o(cond), .dma_err_irq_o(irq)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   endtask

   task automatic do_enable(input logic [3:0] okv, input bit iev, input bit dualv, input logic [1:0] modev);
      @(negedge clk) enable = 1'b0;
      dual = dualv; ie = iev; mode = modev; ok = okv;
      @(negedge clk) enable = 1'b1;
      @(negedge clk);
   endtask

   task automatic start_frame(input logic [2:0] code, input logic [AW-1:0] exp_hdr, input string req);
      @(negedge clk) frame_go = 1'b1;
      @(negedge clk) frame_go = 1'b0;
      chk(req, "hdr_req", hdr_req, 1);
      chk(req, "hdr_addr", hdr_addr, exp_hdr);
      hdr_valid = 1'b1;
      hdr_data = {1'b0, code, 12'h5A5};
      @(negedge clk) hdr_valid = 1'b0;
   endtask

   task automatic frame_head(input logic [2:0] code, input logic [AW-1:0] top, input logic [2:0] exp_cond,
                             input int exp_bpp, input int exp_bytes, input int exp_skip, input string req);
      start_frame(code, top, req);
      @(negedge clk);
      chk(req, "cond", cond, exp_cond);
      chk(req, "pix_base", pix_base, top + exp_skip);
      chk(req, "bpp", bpp, exp_bpp);
      chk(req, "line_bytes", line_bytes, exp_bytes);
   endtask

   task automatic collect(input logic [AW-1:0] base, input int stride, input int first, input int n,
                          input bit stall, input string req);
      for (int i = 0; i < n; i++) begin
         chk(req, "line_valid", line_valid, 1);
         chk(req, "line_addr", line_addr, base + (first + i) * stride);
         if (stall) begin
            @(negedge clk);
            chk(req, "stalled line_addr", line_addr, base + (first + i) * stride);
         end
         line_ready = 1'b1;
         @(negedge clk) line_ready = 1'b0;
      end
      chk("R11", "frame_done", frame_done, 1);
      chk("R11", "line_valid after last", line_valid, 0);
      @(negedge clk) chk("R11", "frame_done one cycle", frame_done, 0);
   endtask

   task automatic quiet(input int cycles, input string req);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         chk(req, "no line_valid", line_valid, 0);
         chk(req, "no frame_done", frame_done, 0);
         chk(req, "no hdr_req", hdr_req, 0);
      end
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R12", "reset active", active, 0);
      chk("R12", "reset line_valid", line_valid, 0);
      chk("R12", "reset hdr_req", hdr_req, 0);
      chk("R6", "reset sync_err", sync_err, 0);
      chk("R5", "reset pal_done", pal_done, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_addr_valid();
      do_enable(4'b1101, 1'b1, 1'b0, 2'd0);
      chk("R10", "cond err bit", cond, 3'b100);
      chk("R10", "irq", irq, 1);
      chk("R10", "not armed", active, 0);
      @(negedge clk) chk("R10", "irq pulse", irq, 0);
      frame_go = 1'b1;
      @(negedge clk) frame_go = 1'b0;
      quiet(3, "R10");
      do_enable(4'b0111, 1'b0, 1'b1, 2'd0);
      chk("R10", "dual cond err", cond, 3'b100);
      chk("R10", "irq masked", irq, 0);
      chk("R10", "dual not armed", active, 0);
      do_enable(4'b0011, 1'b0, 1'b0, 2'd0);
      chk("R10", "single ignores pair 1", active, 1);
      chk("R10", "no cond", cond, 0);
   endtask

   task automatic t_depths();
      frame_head(3'd3, b0t, 3'b001, 8, 16, 'h200, "R1");
      chk("R5", "pal_done", pal_done, 1);
      collect(b0t + 'h200, 16, 0, 4, 1'b0, "R8");
      frame_head(3'd1, b0t, 3'b001, 2, 4, 'h20, "R3");
      collect(b0t + 'h20, 4, 0, 4, 1'b1, "R8");
      frame_head(3'd2, b0t, 3'b001, 4, 8, 'h20, "R1");
      collect(b0t + 'h20, 8, 0, 4, 1'b0, "R8");
      mode = 2'd2;
      frame_head(3'd6, b0t, 3'b001, 16, 32, 0, "R3");
      collect(b0t, 32, 0, 4, 1'b0, "R8");
      mode = 2'd0;
      start_frame(3'd0, b0t, "R2");
      chk("R2", "no cond", cond, 0);
      quiet(4, "R2");
      chk("R2", "still armed", active, 1);
   endtask

   task automatic t_disable_and_modes();
      @(negedge clk) enable = 1'b0;
      @(negedge clk);
      chk("R12", "active cleared", active, 0);
      chk("R12", "pal_done cleared", pal_done, 0);
      frame_go = 1'b1;
      @(negedge clk) frame_go = 1'b0;
      quiet(3, "R12");
      do_enable(4'hF, 1'b0, 1'b0, 2'd1);
      chk("R5", "pal_done clear after enable", pal_done, 0);
      start_frame(3'd3, b0t, "R4");
      chk("R5", "pal_done in mode 1", pal_done, 1);
      chk("R4", "no cond", cond, 0);
      quiet(4, "R4");
      do_enable(4'hF, 1'b0, 1'b0, 2'd2);
      frame_head(3'd3, b0t, 3'b001, 8, 16, 0, "R3");
      chk("R5", "mode 2 keeps pal_done low", pal_done, 0);
      collect(b0t, 16, 0, 4, 1'b0, "R8");
   endtask

   task automatic t_dual();
      do_enable(4'hF, 1'b0, 1'b1, 2'd0);
      frame_head(3'd3, b0t, 3'b001, 8, 16, 'h200, "R7");
      collect(b0t + 'h200, 16, 0, 4, 1'b0, "R7");
      frame_head(3'd3, b1t, 3'b010, 8, 16, 'h200, "R7");
      collect(b1t + 'h200, 16, 0, 4, 1'b0, "R7");
      frame_head(3'd3, b0t, 3'b001, 8, 16, 'h200, "R7");
      collect(b0t + 'h200, 16, 0, 4, 1'b0, "R7");
      do_enable(4'hF, 1'b0, 1'b1, 2'd0);
      frame_head(3'd3, b0t, 3'b001, 8, 16, 'h200, "R7");
      collect(b0t + 'h200, 16, 0, 4, 1'b0, "R7");
      do_enable(4'hF, 1'b0, 1'b0, 2'd0);
   endtask

   task automatic t_subpanel();
      sub_en = 1'b1; sub_start = 1'b1; sub_line = 10'd2;
      frame_head(3'd3, b0t, 3'b001, 8, 16, 'h200, "R9");
      collect(b0t + 'h200, 16, 2, 2, 1'b0, "R9");
      sub_start = 1'b0; sub_line = 10'd1;
      frame_head(3'd3, b0t, 3'b001, 8, 16, 'h200, "R9");
      collect(b0t + 'h200, 16, 0, 1, 1'b0, "R9");
      sub_en = 1'b0;
   endtask

   task automatic t_size();
      b0b = b0t + 'h23E;
      frame_head(3'd3, b0t, 3'b001, 8, 16, 'h200, "R6");
      chk("R6", "exact fit no error", sync_err, 0);
      collect(b0t + 'h200, 16, 0, 4, 1'b0, "R6");
      b0b = b0t + 'h23D;
      start_frame(3'd3, b0t, "R6");
      @(negedge clk);
      chk("R6", "sync_err", sync_err, 1);
      chk("R6", "self disable", active, 0);
      chk("R6", "no cond", cond, 0);
      chk("R6", "no line", line_valid, 0);
      frame_go = 1'b1;
      @(negedge clk) frame_go = 1'b0;
      quiet(3, "R6");
      wm1 = 10'd1023; hm1 = 10'd1023; b0b = 32'hFFFF_0000;
      do_enable(4'hF, 1'b0, 1'b0, 2'd0);
      chk("R12", "sync_err cleared", sync_err, 0);
      frame_head(3'd4, b0t, 3'b001, 16, 2048, 'h200, "R6");
      chk("R6", "large frame fits", sync_err, 0);
      @(negedge clk) enable = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
   end

   initial begin
      t_reset();
      t_addr_valid();
      t_depths();
      t_disable_and_modes();
      t_dual();
      t_subpanel();
      t_size();
      report();
   end
endmodule